// File: doc/BRIEF.md
# Four-Bank SDRAM Command Controller

This block sits between a simple host port and a four-bank, 32-bit synchronous DRAM. After reset it holds the command pins at no-operation for a programmable power-up delay. It then closes every bank, runs two refresh cycles and writes the mode register. Only after that does it raise `ready` and accept host requests.

Each accepted request is a single 32-bit word, read or write, at a word address made of bank, row and column. The block serves it with a closed-page sequence: it opens the row, issues the column command after the row-to-column delay, and closes the bank again before the next command. Write data leaves on the same cycle as the write command, together with an active-high mask per byte lane. Read data comes back on `rd_data` with a one-cycle `rd_valid` pulse. That pulse arrives a fixed number of cycles after the read command, set by the programmed read latency.

A free-running interval counter marks a refresh as due. A due refresh is issued as soon as the access in progress has finished, ahead of any waiting host request. All command and data pins are driven from registers on the rising clock edge.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted, the command pins read {cs_n,ras_n,cas_n,we_n} = 0111 (no-op), and `ready`, `rd_valid` and `sd_dq_oe` are 0.
- R2: After reset release, no command other than no-op appears until at least T_INIT rising edges have passed. The first four commands are then, in order: precharge with address bit 10 set (all banks), refresh, refresh, mode register write. `ready` stays low until the mode write has been issued.
- R3: The mode register write drives bank 0 and the address word CAS_LAT<<4. This means address bits 2:0 = 000 (one-word burst), bit 3 = 0 (sequential order), bits 6:4 = read latency, and all other bits 0.
- R4: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode write 0000, no-op 0111. No other code is ever driven.
- R5: A request is taken at a rising edge where `req` and `ready` are both high. The host address is {bank[2], row[ROW_W], column[COL_W]}. The access issues activate with that bank and row, then read or write with that bank and the column on the low address bits and bit 10 clear. No sooner than T_WR cycles after the column command, it issues precharge of that bank only, with bit 10 clear.
- R6: On the write command cycle, `sd_dq_oe` is 1, `sd_dq_out` equals the request's data, and `sd_dqm[i]` equals the inverse of `be[i]`. Bytes with `be[i]`=0 remain unchanged in memory. `sd_dq_oe` is 0 on every other cycle.
- R7: `rd_valid` pulses for one cycle exactly CAS_LAT+1 cycles after the read command is on the pins. `rd_data` then holds the word the device presents CAS_LAT cycles after it registers the read.
- R8: Once initialization is done, consecutive refresh commands, and the mode write followed by the first refresh, are never more than REF_INT+T_RCD+T_WR+T_RP cycles apart. This holds with or without host traffic.
- R9: A refresh is never issued while any row is open. While a refresh is due and the controller is idle, `ready` is low and no-op is on the pins.
- R10: Command spacing: activate to column command is at least T_RCD cycles; precharge to the next activate or refresh is at least T_RP; refresh to any next command is at least T_RFC; mode write to any next command is at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request |
| ready | output | 1 | Controller accepts a request at this edge |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W+2 | Word address {bank,row,column} |
| wdata | input | DATA_W | Write data |
| be | input | DATA_W/8 | Byte enables, 1 = write this byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ROW_W | Row / column / mode address |
| sd_dqm | output | DATA_W/8 | Byte masks, 1 = masked |
| sd_dq_out | output | DATA_W | Data to device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from device |

## Verification
The bench pairs the controller with a device model. The model drives junk on the data bus in every cycle except the one where read data should appear. A latency off by one therefore returns a wrong word rather than a plausible one. Partial byte-enable writes over known data expose a mask that is inverted or shifted. Accesses to different rows of the same bank and to the top address expose a mis-sliced bank or row field. A long run of back-to-back writes holds `req` high across several refresh intervals: a controller that served requests ahead of a due refresh would exceed the refresh gap bound, and one that refreshed with a row still open would be flagged by the model. The model also times every command gap against the timing parameters, so a wait counter that is one cycle short cannot go unnoticed.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 3,
  parameter int T_INIT  = 20000,
  parameter int REF_INT = 1560,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_RFC   = 7,
  parameter int T_WR    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  output logic                     ready,
  input  logic                     we,
  input  logic [ROW_W+COL_W+1:0]   addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/8-1:0]      be,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [1:0]               sd_ba,
  output logic [ROW_W-1:0]         sd_addr,
  output logic [DATA_W/8-1:0]      sd_dqm,
  output logic [DATA_W-1:0]        sd_dq_out,
  output logic                     sd_dq_oe,
  input  logic [DATA_W-1:0]        sd_dq_in
);
  localparam int NB  = DATA_W / 8;
  localparam int CW  = $clog2(T_INIT + 64) + 1;
  localparam int RFW = $clog2(REF_INT + 1) + 1;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);
  // R4 command codes {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  typedef enum logic [3:0] {S_WAIT, S_IPRE, S_IREF1, S_IREF2, S_IMRS, S_IDLE, S_RW, S_PRE} st_t;

  st_t                    st, ret;
  logic [CW-1:0]          cnt;
  logic [RFW-1:0]         rcnt;
  logic                   ref_pend, ini;
  logic [3:0]             cmd;
  logic [ROW_W+COL_W+1:0] a_q;
  logic                   we_q;
  logic [DATA_W-1:0]      wd_q;
  logic [NB-1:0]          be_q;
  logic [CAS_LAT:0]       rpipe;

  assign ready = (st == S_IDLE) && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; ret <= S_IPRE; cnt <= CW'(T_INIT - 2);
      cmd <= C_NOP; sd_ba <= '0; sd_addr <= '0;
      sd_dq_out <= '0; sd_dq_oe <= 1'b0; sd_dqm <= '0; ini <= 1'b0;
      a_q <= '0; we_q <= 1'b0; wd_q <= '0; be_q <= '0;
    end else begin
      cmd <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm <= '0;
      case (st)
        S_WAIT: if (cnt == '0) st <= ret; else cnt <= cnt - 1'b1;
        S_IPRE: begin
          cmd <= C_PRE; sd_addr <= ALL_BANKS;
          st <= S_WAIT; cnt <= CW'(T_RP - 2); ret <= S_IREF1;
        end
        S_IREF1: begin
          cmd <= C_REF; st <= S_WAIT; cnt <= CW'(T_RFC - 2); ret <= S_IREF2;
        end
        S_IREF2: begin
          cmd <= C_REF; st <= S_WAIT; cnt <= CW'(T_RFC - 2); ret <= S_IMRS;
        end
        S_IMRS: begin
          cmd <= C_MRS; sd_ba <= '0; sd_addr <= MODE_WORD; ini <= 1'b1;
          st <= S_WAIT; cnt <= '0; ret <= S_IDLE;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd <= C_REF; st <= S_WAIT; cnt <= CW'(T_RFC - 2); ret <= S_IDLE;
          end else if (req) begin
            a_q <= addr; we_q <= we; wd_q <= wdata; be_q <= be;
            cmd <= C_ACT; sd_ba <= addr[ROW_W+COL_W +: 2]; sd_addr <= addr[COL_W +: ROW_W];
            st <= S_WAIT; cnt <= CW'(T_RCD - 2); ret <= S_RW;
          end
        end
        S_RW: begin
          cmd <= we_q ? C_WR : C_RD;
          sd_ba <= a_q[ROW_W+COL_W +: 2];
          sd_addr <= ROW_W'(a_q[COL_W-1:0]);
          if (we_q) begin
            sd_dq_out <= wd_q; sd_dq_oe <= 1'b1; sd_dqm <= ~be_q;
          end
          st <= S_WAIT; cnt <= CW'(T_WR - 2); ret <= S_PRE;
        end
        S_PRE: begin
          cmd <= C_PRE; sd_ba <= a_q[ROW_W+COL_W +: 2]; sd_addr <= '0;
          st <= S_WAIT; cnt <= CW'(T_RP - 2); ret <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0; ref_pend <= 1'b0;
    end else begin
      if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (ini) begin
        if (rcnt == RFW'(REF_INT - 1)) begin
          rcnt <= '0; ref_pend <= 1'b1;
        end else rcnt <= rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpipe <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rpipe <= {rpipe[CAS_LAT-1:0], (st == S_RW) && !we_q};
      rd_valid <= rpipe[CAS_LAT];
      if (rpipe[CAS_LAT]) rd_data <= sd_dq_in;
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int ROW_W   = 11,
  parameter int CAS_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             rd_valid,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> cmd == 4'b0100);

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cmd == 4'b0111);

  p_act_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0011 |=> cmd == 4'b0111);

  p_mode_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> sd_addr == ROW_W'(CAS_LAT << 4));

  p_rd_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd == 4'b0101, CAS_LAT + 1) |-> rd_valid);

  p_rd_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd == 4'b0101, CAS_LAT + 1));

  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.ROW_W(ROW_W), .CAS_LAT(CAS_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_cmd_ctrl_test.sv
module sdram_cmd_ctrl_test;
  localparam int CL = 3, TI = 30, RI = 120, TRCD = 3, TRP = 2, TRFC = 5, TWR = 2;
  localparam int GAP = RI + TRCD + TWR + TRP;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
  // {we, addr, wdata, be, expected read}
  localparam logic [89:0] VEC [10] = '{
    {1'b1, 21'h000503, 32'h11223344, 4'hF, 32'h0},
    {1'b1, 21'h180503, 32'hAABBCCDD, 4'hF, 32'h0},
    {1'b0, 21'h000503, 32'h0,        4'h0, 32'h11223344},
    {1'b1, 21'h000503, 32'h55667788, 4'h5, 32'h0},
    {1'b0, 21'h000503, 32'h0,        4'h0, 32'h11663388},
    {1'b0, 21'h180503, 32'h0,        4'h0, 32'hAABBCCDD},
    {1'b1, 21'h02BCFF, 32'hCAFEF00D, 4'h8, 32'h0},
    {1'b0, 21'h02BCFF, 32'h0,        4'h0, 32'hCA000000},
    {1'b1, 21'h1FFFFF, 32'h0F0F0F0F, 4'hF, 32'h0},
    {1'b0, 21'h1FFFFF, 32'h0,        4'h0, 32'h0F0F0F0F}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0, rd_data, sd_dq_out, sd_dq_in = 32'hDEADBEEF;
  logic [3:0] be = '0, sd_dqm;
  logic ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [10:0] sd_addr;

  sdram_cmd_ctrl #(.CAS_LAT(CL), .T_INIT(TI), .REF_INT(RI), .T_RCD(TRCD), .T_RP(TRP),
                   .T_RFC(TRFC), .T_WR(TWR)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .we(we), .addr(addr),
    .wdata(wdata), .be(be), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // accepted request as seen by the model
  logic [20:0] q_addr; logic [31:0] q_wd; logic [3:0] q_be;

  // device model
  logic [31:0] mem [int];
  int cyc = 0, rdc = 0, t_rd = -1000, t_rw = -1000, t_pre = -1000, t_ref = -1000, t_mrs = -1000;
  int last_ref = 0, nref = 0, iidx = 0;
  int t_act [4];
  logic [10:0] arow [4];
  logic [3:0] open_b = '0;
  bit init_done = 0, early_ready = 0;
  logic [31:0] rword;
  logic [3:0] ini_seq [4] = '{C_PRE, C_REF, C_REF, C_MRS};

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    int key;
    cyc++;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    sd_dq_in = 32'hDEADBEEF;
    if (rdc > 0) begin
      rdc--;
      if (rdc == 0) sd_dq_in = rword;
    end
    if (ready && !init_done) early_ready = 1;
    if (rd_valid) chk(cyc - t_rd == CL + 1, "R7 read latency", cyc - t_rd, CL + 1);
    if (sd_dq_oe && c != C_WR) chk(0, "R6 oe outside write", {28'b0, c}, C_WR);
    if (c != C_NOP) begin
      chk(cyc - t_ref >= TRFC, "R10 refresh spacing", cyc - t_ref, TRFC);
      chk(cyc - t_mrs >= 2, "R10 mode spacing", cyc - t_mrs, 2);
      if (!init_done && iidx < 4) begin
        if (iidx == 0) begin
          chk(cyc >= TI, "R2 power-up wait", cyc, TI);
          chk(sd_addr[10] == 1'b1, "R2 precharge all", {31'b0, sd_addr[10]}, 1);
        end
        chk(c == ini_seq[iidx], "R2 init order", {28'b0, c}, {28'b0, ini_seq[iidx]});
        iidx++;
      end
      case (c)
        C_ACT: begin
          chk(!open_b[sd_ba], "R5 activate on open bank", {28'b0, open_b}, 0);
          chk(cyc - t_pre >= TRP, "R10 precharge to activate", cyc - t_pre, TRP);
          chk({sd_ba, sd_addr} == q_addr[20:8], "R5 bank/row", {19'b0, sd_ba, sd_addr}, {19'b0, q_addr[20:8]});
          open_b[sd_ba] = 1'b1; t_act[sd_ba] = cyc; arow[sd_ba] = sd_addr;
        end
        C_RD, C_WR: begin
          chk(open_b[sd_ba], "R5 column command on closed bank", {28'b0, open_b}, 1);
          chk(cyc - t_act[sd_ba] >= TRCD, "R10 activate to column", cyc - t_act[sd_ba], TRCD);
          chk(sd_addr == {3'b0, q_addr[7:0]} && sd_ba == q_addr[20:19], "R5 column address",
              {19'b0, sd_ba, sd_addr}, {19'b0, q_addr[20:19], 3'b0, q_addr[7:0]});
          key = int'({sd_ba, arow[sd_ba], sd_addr[7:0]});
          rword = mem.exists(key) ? mem[key] : 32'h0;
          t_rw = cyc;
          if (c == C_WR) begin
            chk(sd_dq_oe && sd_dq_out == q_wd, "R6 write data", sd_dq_out, q_wd);
            chk(sd_dqm == ~q_be, "R6 byte masks", {28'b0, sd_dqm}, {28'b0, ~q_be});
            for (int b = 0; b < 4; b++)
              if (!sd_dqm[b]) rword[b*8 +: 8] = sd_dq_out[b*8 +: 8];
            mem[key] = rword;
          end else begin
            rdc = CL; t_rd = cyc;
          end
        end
        C_PRE: begin
          if (sd_addr[10]) open_b = '0;
          else begin
            chk(cyc - t_rw >= TWR, "R5 column to precharge", cyc - t_rw, TWR);
            open_b[sd_ba] = 1'b0;
          end
          t_pre = cyc;
        end
        C_REF: begin
          chk(open_b == '0, "R9 refresh with open row", {28'b0, open_b}, 0);
          chk(cyc - t_pre >= TRP, "R10 precharge to refresh", cyc - t_pre, TRP);
          if (init_done) begin
            chk(cyc - last_ref <= GAP, "R8 refresh gap", cyc - last_ref, GAP);
            nref++;
          end
          last_ref = cyc; t_ref = cyc;
        end
        C_MRS: begin
          chk(sd_addr == 11'(CL << 4) && sd_ba == 2'b0, "R3 mode word", {19'b0, sd_ba, sd_addr}, CL << 4);
          init_done = 1; last_ref = cyc; t_mrs = cyc;
        end
        default: chk(0, "R4 unknown command", {28'b0, c}, C_NOP);
      endcase
    end
  end

  task automatic access(input bit w, input logic [20:0] a, input logic [31:0] d,
                        input logic [3:0] b, output logic [31:0] rd);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    while (!ready) @(negedge clk);
    q_addr = a; q_wd = d; q_be = b;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    rd = 32'h0;
    if (!w) begin
      for (int i = 0; i < 20 && !rd_valid; i++) @(negedge clk);
      chk(rd_valid, "R7 read returned", {31'b0, rd_valid}, 1);
      rd = rd_data;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog (R1-wide run)", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
        {28'b0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(!ready && !rd_valid && !sd_dq_oe, "R1 reset outputs", {29'b0, ready, rd_valid, sd_dq_oe}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // table walk
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][89], VEC[i][88:68], VEC[i][67:36], VEC[i][35:32], r);
      if (!VEC[i][89]) chk(r == VEC[i][31:0], "R7 read data", r, VEC[i][31:0]);
    end
    chk(!early_ready, "R2 ready before init", {31'b0, early_ready}, 0);
    chk(iidx == 4, "R2 init commands seen", iidx, 4);
    // back-to-back writes across refresh intervals (R8, R9)
    for (int i = 0; i < 24; i++)
      access(1'b1, {i[1:0], 11'(i * 37 + 1), 8'(i * 5)}, 32'h01010101 * (i + 1) ^ 32'hA5000000, 4'hF, r);
    for (int i = 0; i < 24; i++) begin
      access(1'b0, {i[1:0], 11'(i * 37 + 1), 8'(i * 5)}, 32'h0, 4'h0, r);
      chk(r == (32'h01010101 * (i + 1) ^ 32'hA5000000), "R5 back-to-back readback",
          r, 32'h01010101 * (i + 1) ^ 32'hA5000000);
    end
    chk(nref >= 3, "R8 refreshes under traffic", nref, 3);
    // idle: refresh continues without traffic
    nref = 0;
    repeat (3 * RI) @(negedge clk);
    chk(nref >= 2, "R8 refreshes while idle", nref, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule